// File: doc/BRIEF.md
# Programmable pulse generator timer

This block is a 16-bit up-counting timer that turns two compare values into a periodic rectangular waveform on a single output. The counter advances once per count tick, and a selectable divider derives that tick from the block clock. When the count equals the period value, the counter returns to zero on that tick. When the count equals the mark value, the counter keeps running. Each of the two matches inverts one output flip-flop and raises its own one-cycle interrupt pulse. The period is therefore `period + 1` ticks, and the level that follows the mark match lasts `period - mark` ticks.

Software sets the block up through a small write port. The first address holds the period value, the second holds the mark value, and the third is the control word. The control word selects the divider and carries the output enable, the initial level of the flip-flop and the run bit. The count value can be read on a dedicated output at any time, and reading it does not disturb counting. Correct waveforms need `mark < period`.

Top module: `ppg_timer`

## Requirements
- R1: After reset, `cnt_o` is 0 and `pulse_o`, `irq_period_o` and `irq_mark_o` are all 0. The period and mark values reset to 0, and every control field resets to 0.
- R2: Control bits [1:0] select the count tick rate. The codes 0, 1, 2 and 3 advance the counter once every 1, 4, 16 and 256 clocks. After a start, the first advance happens on the Nth clock edge following the start edge.
- R3: On a count tick where `cnt_o` equals the period value (address 0), the counter goes to 0. On any other tick it increments by one.
- R4: On a count tick where `cnt_o` equals the mark value (address 1), the counter still increments and is not cleared.
- R5: Each period match and each mark match inverts the output flip-flop. Each match also drives its own interrupt output (`irq_period_o` or `irq_mark_o`) high for exactly the one clock after the tick edge.
- R6: Control bit 2 is the output enable. When it is 1, `pulse_o` shows the flip-flop level. When it is 0, `pulse_o` is held at 0.
- R7: A write to the control word at address 2 with bit 4 = 1, made while the timer is stopped, starts it. On that edge the counter clears, the flip-flop loads control bit 3, and the divider restarts from zero. A write with bit 4 = 1 while the timer is already running does not restart it.
- R8: While the run bit is 0, `cnt_o` holds its value and no interrupts occur.
- R9: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = period, 1 = mark, 2 = control |
| wr_data | input | 16 | Write data; control uses bits [4:0] |
| cnt_o | output | 16 | Current count value |
| irq_period_o | output | 1 | One-cycle pulse on a period match |
| irq_mark_o | output | 1 | One-cycle pulse on a mark match |
| pulse_o | output | 1 | Gated flip-flop output |

## Verification
The hardest case to reach from the ports is a restart in the divide-by-256 mode while the divider is partway through its cycle. A wrong divider reset would only show as a first tick that comes too early, up to 255 clocks off. To reach it, the stimulus runs the timer for a stretch that is not a multiple of 256 clocks, then stops and restarts it. It then checks that the count stays at zero for exactly 255 edges and reads one on the 256th. The stimulus also switches the divider rate while the timer is running, and it turns the output enable off mid-run. Every clock is compared against a behavioural model.

// File: rtl/ppg_pkg.sv
// Shared definitions for the pulse generator timer: register map and divider codes.
package ppg_pkg;
    localparam int DIV_W = 8;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16  = 2'd2,
        PS_DIV256 = 2'd3
    } ps_sel_e;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_MARK   = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CTL_OE   = 2;
    localparam int CTL_INIT = 3;
    localparam int CTL_RUN  = 4;

    // Low-bit mask of the divider whose all-ones pattern marks a tick.
    function automatic logic [DIV_W-1:0] ps_mask(input ps_sel_e sel);
        case (sel)
            PS_DIV1:  ps_mask = DIV_W'(0);
            PS_DIV4:  ps_mask = DIV_W'(3);
            PS_DIV16: ps_mask = DIV_W'(15);
            default:  ps_mask = DIV_W'(255);
        endcase
    endfunction
endpackage

// File: rtl/ppg_prescaler.sv
// Count-tick generator. A free-running divider that advances while the timer runs.
// A tick fires when the selected low bits of the divider are all ones.
// Assumes: clear is a single-cycle restart request.
module ppg_prescaler
    import ppg_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    run,
    input  ps_sel_e sel,
    output logic    tick
);
    logic [W-1:0] div_q;
    logic [W-1:0] mask;

    // Divider: zeroed on reset or restart, advances only while running.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (clear) div_q <= '0;
        else if (run)   div_q <= div_q + 1'b1;
    end

    // Tick decode: the selected low bits are all set.
    always_comb begin
        mask = W'(ps_mask(sel));
        tick = run && ((div_q & mask) == mask);
    end
endmodule

// File: rtl/ppg_counter.sv
// Up counter with two comparators. The period match wraps the count to zero.
// The mark match only reports and leaves the count running.
// Assumes: match flags are used only on the edge of the tick that produced them.
module ppg_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic [W-1:0] mark,
    output logic [W-1:0] cnt,
    output logic         hit_period,
    output logic         hit_mark
);
    // Compare decode, qualified by the count tick.
    always_comb begin
        hit_period = tick && (cnt == period);
        hit_mark   = tick && (cnt == mark);
    end

    // Count register: restart, wrap on period match, else increment on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (hit_period) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ppg_outff.sv
// Output flip-flop with a loadable initial level and an enable gate.
// Assumes: the two toggle requests never coincide under legal compare ordering.
// If they do, the two inversions cancel.
module ppg_outff (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic init,
    input  logic tog_a,
    input  logic tog_b,
    input  logic oe,
    output logic ff_q,
    output logic pulse
);
    // Level register: load on start, invert once per match.
    always_ff @(posedge clk) begin
        if (!rst_n)    ff_q <= 1'b0;
        else if (load) ff_q <= init;
        else           ff_q <= ff_q ^ (tog_a ^ tog_b);
    end

    // Pin gate: inactive low when disabled.
    always_comb pulse = oe & ff_q;
endmodule

// File: rtl/ppg_timer.sv
// Top of the pulse generator timer: register file, start detection, interrupt registers.
// Assumes: software keeps mark < period for a well-formed waveform.
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_period_o,
    output logic              irq_mark_o,
    output logic              pulse_o
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] mark_q;
    ps_sel_e          sel_q;
    logic             oe_q;
    logic             run_q;
    logic             ff_q;
    logic             start;
    logic             tick;
    logic             hit_p;
    logic             hit_m;
    logic             ctl_wr;

    // Start decode: control write that turns a stopped timer on.
    always_comb begin
        ctl_wr = wr_en && (wr_addr == ADDR_CTRL);
        start  = ctl_wr && wr_data[CTL_RUN] && !run_q;
    end

    // Register file: compare values and control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            mark_q   <= '0;
            sel_q    <= PS_DIV1;
            oe_q     <= 1'b0;
            run_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD: period_q <= CNT_W'(wr_data);
                ADDR_MARK:   mark_q   <= CNT_W'(wr_data);
                ADDR_CTRL: begin
                    sel_q <= ps_sel_e'(wr_data[1:0]);
                    oe_q  <= wr_data[CTL_OE];
                    run_q <= wr_data[CTL_RUN];
                end
                default: ;
            endcase
        end
    end

    ppg_prescaler #(.W(DIV_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (run_q),
        .sel   (sel_q),
        .tick  (tick)
    );

    ppg_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .tick       (tick),
        .period     (period_q),
        .mark       (mark_q),
        .cnt        (cnt_o),
        .hit_period (hit_p),
        .hit_mark   (hit_m)
    );

    ppg_outff u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .init  (wr_data[CTL_INIT]),
        .tog_a (hit_p),
        .tog_b (hit_m),
        .oe    (oe_q),
        .ff_q  (ff_q),
        .pulse (pulse_o)
    );

    // Interrupt registers: one-cycle pulse after each match edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_period_o <= 1'b0;
            irq_mark_o   <= 1'b0;
        end else begin
            irq_period_o <= hit_p;
            irq_mark_o   <= hit_m;
        end
    end
endmodule

// File: rtl/ppg_timer_chk.sv
// Property checker for the pulse generator timer, attached to every instance by bind.
module ppg_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_o,
    input logic             irq_period_o,
    input logic             irq_mark_o,
    input logic             pulse_o,
    input logic             oe_q,
    input logic             run_q,
    input logic             ff_q
);
    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period_o |-> (cnt_o == '0));

    // R4
    mark_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mark_o |-> (cnt_o != '0));

    // R5
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_period_o || irq_mark_o) |-> (ff_q != $past(ff_q)));

    // R5
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_period_o && irq_mark_o));

    // R6
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> !pulse_o);

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !$past(run_q)) |-> ($stable(cnt_o) && !irq_period_o && !irq_mark_o));
endmodule

bind ppg_timer ppg_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_o        (cnt_o),
    .irq_period_o (irq_period_o),
    .irq_mark_o   (irq_mark_o),
    .pulse_o      (pulse_o),
    .oe_q         (oe_q),
    .run_q        (run_q),
    .ff_q         (ff_q)
);

// File: tb/ppg_timer_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module ppg_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic        irq_period_o, irq_mark_o, pulse_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;

    // reference model state
    int m_period, m_mark, m_sel, m_oe, m_init, m_run, m_div, m_cnt, m_ff, m_irqp, m_irqm;

    always #5 clk = ~clk;

    ppg_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .irq_period_o(irq_period_o), .irq_mark_o(irq_mark_o), .pulse_o(pulse_o)
    );

    function automatic int div_mask(int s);
        case (s)
            0: return 0;
            1: return 3;
            2: return 15;
            default: return 255;
        endcase
    endfunction

    // Reference model: advances once per rising edge from the spec alone.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_period = 0; m_mark = 0; m_sel = 0; m_oe = 0; m_init = 0; m_run = 0;
            m_div = 0; m_cnt = 0; m_ff = 0; m_irqp = 0; m_irqm = 0;
        end else begin
            bit tk, mp, mm, st;
            tk = (m_run != 0) && ((m_div & div_mask(m_sel)) == div_mask(m_sel));
            mp = tk && (m_cnt == m_period);
            mm = tk && (m_cnt == m_mark);
            st = wr_en && wr_addr == 2 && wr_data[4] && m_run == 0;
            m_irqp = mp;
            m_irqm = mm;
            if (st) begin
                m_cnt = 0; m_div = 0; m_ff = wr_data[3];
            end else begin
                if (mp) m_cnt = 0;
                else if (tk) m_cnt = (m_cnt + 1) % 65536;
                if (mp != mm) m_ff = 1 - m_ff;
                if (m_run != 0) m_div = (m_div + 1) % 256;
            end
            if (wr_en) begin
                if (wr_addr == 0) m_period = wr_data;
                else if (wr_addr == 1) m_mark = wr_data;
                else if (wr_addr == 2) begin
                    m_sel = wr_data[1:0]; m_oe = wr_data[2]; m_run = wr_data[4];
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cmp_en && rst_n) begin
            check("R3 count", cnt_o, m_cnt);
            check("R5 pulse", pulse_o, (m_oe != 0) ? m_ff : 0);
            check("R5 period irq", irq_period_o, m_irqp);
            check("R5 mark irq", irq_mark_o, m_irqm);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        // R1 reset state
        check("R1 count", cnt_o, 0);
        check("R1 pulse", pulse_o, 0);
        check("R1 irqs", {irq_period_o, irq_mark_o}, 0);

        wr(0, 16'd9);
        wr(1, 16'd4);
        wr(2, 16'h0014);              // run, enable, init 0, divide by 1
        check("R7 start count", cnt_o, 0);
        idle(5);
        check("R2 div1 advance", cnt_o, 5);
        check("R4 mark leaves count", cnt_o, 5);
        check("R5 toggled at mark", pulse_o, 1);
        idle(100);

        wr(3, 16'h0000);              // R9 ignored write
        idle(40);

        wr(2, 16'h0010);              // R6 enable off while running
        for (int i = 0; i < 40; i++) begin
            check("R6 gated low", pulse_o, 0);
            @(negedge clk);
        end

        wr(2, 16'h0014);              // R7 run already set: no restart
        idle(30);

        wr(2, 16'h0004);              // R8 stop
        snap = cnt_o;
        for (int i = 0; i < 20; i++) begin
            check("R8 hold", cnt_o, snap);
            @(negedge clk);
        end

        wr(2, 16'h001E);              // start, init 1, enable, divide by 16
        check("R7 cleared", cnt_o, 0);
        check("R7 init level", pulse_o, 1);
        idle(15);
        check("R2 div16 before", cnt_o, 0);
        idle(1);
        check("R2 div16 first", cnt_o, 1);
        idle(400);

        wr(2, 16'h0007);              // stop, divide by 256
        wr(0, 16'd3);
        wr(1, 16'd1);
        wr(2, 16'h0017);
        idle(300);
        wr(2, 16'h0007);
        wr(2, 16'h0017);              // R7 divider restarts mid-cycle
        idle(255);
        check("R7 div256 before", cnt_o, 0);
        idle(1);
        check("R2 div256 first", cnt_o, 1);
        idle(2500);

        wr(2, 16'h0015);              // rate change while running to divide by 4
        idle(120);
        wr(2, 16'h0005);
        wr(2, 16'h0015);
        idle(3);
        check("R2 div4 before", cnt_o, 0);
        idle(1);
        check("R2 div4 first", cnt_o, 1);
        idle(100);

        cmp_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule